// File: doc/BRIEF.md
# Eight-bit arithmetic and flag unit

This block is the purely combinational arithmetic and logic stage of a small 8-bit processor. Each cycle it receives an operation code, the accumulator, a second byte operand, two 16-bit register pairs and the four stored condition flags. It returns three things. The first is an 8-bit result with a write strobe. The second is a 16-bit result with its own strobe. The third is a new flag vector, paired with a per-flag write-enable vector. The register stage uses these strobes to decide what to commit.

The flags are zero (Z), subtract (N), half-carry (H) and carry (C). They are packed into a 4-bit vector with Z in bit 3, N in bit 2, H in bit 1 and C in bit 0. The half-carry comes from bit 3 for byte operations and from bit 11 for the 16-bit pair add. Every flag that an operation does not write is passed through unchanged on the output, and its write-enable bit is low. The decimal-adjust operation reads the stored N, H and C flags to correct the accumulator after a BCD add or subtract.

Top module: `alu8_core`

## Requirements
- R1: Operation codes: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 AND, 6 XOR, 7 OR, 8 increment, 9 decrement, 10 decimal adjust, 11 complement, 12 set carry, 13 complement carry, 14 pair add, 15 no operation. For add (0) and add-with-carry (1), the result is acc + opnd (+ C for code 1) modulo 256. H is the carry out of bit 3, C is the carry out of bit 7, N is 0 and Z is set when the result is 0. All four flags are written and res_we is 1.
- R2: For subtract (2) and subtract-with-borrow (3), the result is acc − opnd (− C for code 3) modulo 256. N is 1, H is the borrow out of the low nibble, C is the borrow out of the whole byte and Z is set when the result is 0. All four flags are written and res_we is 1.
- R3: Compare (4) sets the flags exactly as subtract does, but res_we is 0.
- R4: AND (5) gives Z from the result, sets H and clears N and C. XOR (6) and OR (7) give Z from the result and clear N, H and C. All four flags are written and res_we is 1.
- R5: Increment (8) and decrement (9) act on opnd and give opnd ± 1 modulo 256 with res_we 1. They write Z and H (H is the nibble carry or borrow). N is 0 for increment and 1 for decrement. C is not written and passes through.
- R6: Decimal adjust (10) acts on acc. The adjustment is 0x06 when H is set, or when N is clear and acc[3:0] > 9. A further 0x60 is included when C is set, or when N is clear and acc > 0x99, and in that case the new C is 1; otherwise the new C is 0. The adjustment is added when N is 0 and subtracted when N is 1. H is cleared, Z comes from the result, N is not written, and res_we is 1.
- R7: When N is clear and C is set, decimal adjust always outputs C = 1.
- R8: Complement (11) outputs ~acc with res_we 1 and writes N = 1, H = 1. Set carry (12) writes C = 1, N = 0, H = 0. Complement carry (13) writes C = !C, N = 0, H = 0. Neither 12 nor 13 asserts res_we.
- R9: Pair add (14) outputs hl + rr modulo 65536 on wide_result with wide_we 1. H is the carry out of bit 11, C is the carry out of bit 15 and N is 0. Z is not written. res_we is 0.
- R10: For every operation, a flag whose flag_we bit is 0 appears on flags_out unchanged from flags_in. Code 15 writes nothing: flag_we is 0, res_we is 0 and wide_we is 0. wide_we is 1 only for code 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code (see R1) |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second byte operand; target of increment and decrement |
| hl_in | input | 16 | Destination pair for the 16-bit add |
| rr_in | input | 16 | Source pair for the 16-bit add |
| flags_in | input | 4 | Stored flags {Z,N,H,C} |
| result | output | 8 | Byte result |
| res_we | output | 1 | Byte result is to be committed |
| wide_result | output | 16 | Pair-add result |
| wide_we | output | 1 | Pair result is to be committed |
| flags_out | output | 4 | New flags {Z,N,H,C} |
| flag_we | output | 4 | Per-flag commit enables, same bit order |

## Verification
The unit holds no state. A wrong internal choice therefore shows at the ports in the same cycle as the stimulus. It can appear as a wrong sum, a misplaced nibble carry, a decimal correction that ignores the stored N, H or C, or a write enable that lets a flag meant to be preserved be overwritten. Because the error is visible immediately, a reference model compared on every cycle catches it on the first vector that exercises it. Directed vectors cover the nibble and byte boundaries, the sticky decimal carry and the bit-11 pair carry. Random vectors cover the rest of the operand space.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_ADC   = 4'd1,
      OP_SUB   = 4'd2,
      OP_SBC   = 4'd3,
      OP_CMP   = 4'd4,
      OP_AND   = 4'd5,
      OP_XOR   = 4'd6,
      OP_OR    = 4'd7,
      OP_INC   = 4'd8,
      OP_DEC   = 4'd9,
      OP_DADJ  = 4'd10,
      OP_CPL   = 4'd11,
      OP_SETC  = 4'd12,
      OP_CMPLC = 4'd13,
      OP_ADDW  = 4'd14,
      OP_NONE  = 4'd15
   } alu_op_e;

   localparam int FL_Z = 3;
   localparam int FL_N = 2;
   localparam int FL_H = 1;
   localparam int FL_C = 0;
   localparam int FL_COUNT = 4;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int W   = 8,
   parameter int NIB = 4
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         half,
   output logic         carry
);
   logic [W-1:0] y_eff;
   logic         c_eff;
   logic [NIB:0] low;
   logic [W:0]   full;

   always_comb begin
      y_eff = sub ? ~y : y;
      c_eff = sub ? ~cin : cin;
      low   = {1'b0, x[NIB-1:0]} + {1'b0, y_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
      full  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, c_eff};
      sum   = full[W-1:0];
      half  = sub ? ~low[NIB] : low[NIB];
      carry = sub ? ~full[W] : full[W];
   end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
   parameter int W   = 8,
   parameter int NIB = 4
) (
   input  logic [W-1:0] a,
   input  logic         n_in,
   input  logic         h_in,
   input  logic         c_in,
   output logic [W-1:0] res,
   output logic         c_out
);
   localparam logic [NIB-1:0] DIGIT_MAX  = NIB'(9);
   localparam logic [NIB-1:0] DIGIT_FIX  = NIB'(6);
   localparam logic [W-1:0]   BYTE_MAX   = {DIGIT_MAX, DIGIT_MAX};

   logic         fix_lo;
   logic         fix_hi;
   logic [W-1:0] adj;

   always_comb begin
      fix_lo = h_in | (!n_in && (a[NIB-1:0] > DIGIT_MAX));
      fix_hi = c_in | (!n_in && (a > BYTE_MAX));
      adj    = {(fix_hi ? DIGIT_FIX : {NIB{1'b0}}), (fix_lo ? DIGIT_FIX : {NIB{1'b0}})};
      res    = n_in ? (a - adj) : (a + adj);
      c_out  = fix_hi;
   end
endmodule

// File: rtl/alu8_wideadd.sv
module alu8_wideadd #(
   parameter int W         = 8,
   parameter int NIB       = 4,
   parameter bit SPLIT_ADD = 1'b0
) (
   input  logic [2*W-1:0] p,
   input  logic [2*W-1:0] q,
   output logic [2*W-1:0] sum,
   output logic           half,
   output logic           carry
);
   localparam int WW = 2 * W;
   localparam int HB = WW - NIB;

   generate
      if (SPLIT_ADD) begin : g_split
         logic [W:0]   lo_s;
         logic [NIB:0] mid_s;
         logic [W:0]   hi_s;
         always_comb begin
            lo_s  = {1'b0, p[W-1:0]} + {1'b0, q[W-1:0]};
            mid_s = {1'b0, p[W+NIB-1:W]} + {1'b0, q[W+NIB-1:W]} + {{NIB{1'b0}}, lo_s[W]};
            hi_s  = {1'b0, p[WW-1:W]} + {1'b0, q[WW-1:W]} + {{W{1'b0}}, lo_s[W]};
            sum   = {hi_s[W-1:0], lo_s[W-1:0]};
            half  = mid_s[NIB];
            carry = hi_s[W];
         end
      end else begin : g_flat
         logic [HB:0] part_s;
         logic [WW:0] all_s;
         always_comb begin
            part_s = {1'b0, p[HB-1:0]} + {1'b0, q[HB-1:0]};
            all_s  = {1'b0, p} + {1'b0, q};
            sum    = all_s[WW-1:0];
            half   = part_s[HB];
            carry  = all_s[WW];
         end
      end
   endgenerate
endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int W         = 8,
   parameter int NIB       = 4,
   parameter bit SPLIT_ADD = 1'b0
) (
   input  logic [3:0]     op,
   input  logic [W-1:0]   acc_in,
   input  logic [W-1:0]   opnd_in,
   input  logic [2*W-1:0] hl_in,
   input  logic [2*W-1:0] rr_in,
   input  logic [3:0]     flags_in,
   output logic [W-1:0]   result,
   output logic           res_we,
   output logic [2*W-1:0] wide_result,
   output logic           wide_we,
   output logic [3:0]     flags_out,
   output logic [3:0]     flag_we
);
   localparam logic [W-1:0] ONE = W'(1);

   if (W != 2 * NIB) begin : g_chk_w
      $error("alu8_core: W must be twice NIB");
   end
   if (NIB != 4) begin : g_chk_nib
      $error("alu8_core: decimal adjust needs 4-bit digits");
   end

   alu_op_e opc;
   assign opc = alu_op_e'(op);

   logic         step_op;
   logic         sub_op;
   logic [W-1:0] as_x, as_y, as_sum;
   logic         as_cin, as_half, as_carry;

   always_comb begin
      step_op = (opc == OP_INC) || (opc == OP_DEC);
      sub_op  = (opc == OP_SUB) || (opc == OP_SBC) || (opc == OP_CMP) || (opc == OP_DEC);
      as_x    = step_op ? opnd_in : acc_in;
      as_y    = step_op ? ONE : opnd_in;
      as_cin  = ((opc == OP_ADC) || (opc == OP_SBC)) && flags_in[FL_C];
   end

   alu8_addsub #(.W(W), .NIB(NIB)) u_addsub (
      .x(as_x), .y(as_y), .cin(as_cin), .sub(sub_op),
      .sum(as_sum), .half(as_half), .carry(as_carry)
   );

   logic [W-1:0] da_res;
   logic         da_c;

   alu8_decadj #(.W(W), .NIB(NIB)) u_decadj (
      .a(acc_in), .n_in(flags_in[FL_N]), .h_in(flags_in[FL_H]), .c_in(flags_in[FL_C]),
      .res(da_res), .c_out(da_c)
   );

   logic [2*W-1:0] wa_sum;
   logic           wa_half, wa_carry;

   alu8_wideadd #(.W(W), .NIB(NIB), .SPLIT_ADD(SPLIT_ADD)) u_wideadd (
      .p(hl_in), .q(rr_in), .sum(wa_sum), .half(wa_half), .carry(wa_carry)
   );

   logic [W-1:0] bit_res;

   always_comb begin
      unique case (opc)
         OP_AND:  bit_res = acc_in & opnd_in;
         OP_XOR:  bit_res = acc_in ^ opnd_in;
         default: bit_res = acc_in | opnd_in;
      endcase
   end

   always_comb begin
      result      = acc_in;
      res_we      = 1'b0;
      wide_result = wa_sum;
      wide_we     = 1'b0;
      flags_out   = flags_in;
      flag_we     = 4'b0000;
      unique case (opc)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
            result          = as_sum;
            res_we          = (opc != OP_CMP);
            flag_we         = 4'b1111;
            flags_out[FL_Z] = (as_sum == '0);
            flags_out[FL_N] = sub_op;
            flags_out[FL_H] = as_half;
            flags_out[FL_C] = as_carry;
         end
         OP_AND, OP_XOR, OP_OR: begin
            result          = bit_res;
            res_we          = 1'b1;
            flag_we         = 4'b1111;
            flags_out[FL_Z] = (bit_res == '0);
            flags_out[FL_N] = 1'b0;
            flags_out[FL_H] = (opc == OP_AND);
            flags_out[FL_C] = 1'b0;
         end
         OP_INC, OP_DEC: begin
            result          = as_sum;
            res_we          = 1'b1;
            flag_we         = 4'b1110;
            flags_out[FL_Z] = (as_sum == '0);
            flags_out[FL_N] = sub_op;
            flags_out[FL_H] = as_half;
         end
         OP_DADJ: begin
            result          = da_res;
            res_we          = 1'b1;
            flag_we         = 4'b1011;
            flags_out[FL_Z] = (da_res == '0);
            flags_out[FL_H] = 1'b0;
            flags_out[FL_C] = da_c;
         end
         OP_CPL: begin
            result          = ~acc_in;
            res_we          = 1'b1;
            flag_we         = 4'b0110;
            flags_out[FL_N] = 1'b1;
            flags_out[FL_H] = 1'b1;
         end
         OP_SETC, OP_CMPLC: begin
            flag_we         = 4'b0111;
            flags_out[FL_N] = 1'b0;
            flags_out[FL_H] = 1'b0;
            flags_out[FL_C] = (opc == OP_SETC) ? 1'b1 : !flags_in[FL_C];
         end
         OP_ADDW: begin
            wide_we         = 1'b1;
            flag_we         = 4'b0111;
            flags_out[FL_N] = 1'b0;
            flags_out[FL_H] = wa_half;
            flags_out[FL_C] = wa_carry;
         end
         default: begin
         end
      endcase
   end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
   parameter int W = 8
) (
   input logic [3:0]     op,
   input logic [W-1:0]   acc_in,
   input logic [W-1:0]   opnd_in,
   input logic [3:0]     flags_in,
   input logic [W-1:0]   result,
   input logic           res_we,
   input logic           wide_we,
   input logic [3:0]     flags_out,
   input logic [3:0]     flag_we
);
   logic known;
   assign known = !$isunknown({op, acc_in, opnd_in, flags_in});

   always_comb begin
      if (known) begin
         for (int i = 0; i < 4; i++) begin
            assert_keep_unwritten_R10: assert (flag_we[i] || (flags_out[i] == flags_in[i]))
               else $error("unwritten flag %0d changed", i);
         end
         assert_wide_only_pair_R10: assert (wide_we == (op == 4'd14))
            else $error("wide_we on wrong op");
         assert_cmp_no_write_R3: assert (op != 4'd4 || !res_we)
            else $error("compare wrote result");
         assert_and_sets_h_R4: assert (op != 4'd5 || (flags_out[1] && !flags_out[0]))
            else $error("AND flags wrong");
         assert_step_keeps_c_R5: assert (!(op == 4'd8 || op == 4'd9) || (flags_out[0] == flags_in[0]))
            else $error("inc/dec touched C");
         assert_dadj_sticky_c_R7: assert (!(op == 4'd10 && !flags_in[2] && flags_in[0]) || flags_out[0])
            else $error("decimal adjust dropped carry");
         assert_cpl_value_R8: assert (op != 4'd11 || (result == ~acc_in))
            else $error("complement value wrong");
         assert_pair_keeps_z_R9: assert (op != 4'd14 || (flags_out[3] == flags_in[3]))
            else $error("pair add touched Z");
      end
   end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
   .op(op), .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
   .result(result), .res_we(res_we), .wide_we(wide_we),
   .flags_out(flags_out), .flag_we(flag_we)
);

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [3:0]  op;
   logic [7:0]  acc_in, opnd_in, result;
   logic [15:0] hl_in, rr_in, wide_result;
   logic [3:0]  flags_in, flags_out, flag_we;
   logic        res_we, wide_we;

   alu8_core dut (
      .op(op), .acc_in(acc_in), .opnd_in(opnd_in), .hl_in(hl_in), .rr_in(rr_in),
      .flags_in(flags_in), .result(result), .res_we(res_we),
      .wide_result(wide_result), .wide_we(wide_we),
      .flags_out(flags_out), .flag_we(flag_we)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // expected values
   logic [7:0]  e_res;
   logic [15:0] e_wide;
   logic        e_rwe, e_wwe;
   logic [3:0]  e_fl, e_we;

   function automatic string tag_of(input logic [3:0] o, input logic [3:0] f);
      case (o)
         4'd0, 4'd1:  return "R1";
         4'd2, 4'd3:  return "R2";
         4'd4:        return "R3";
         4'd5, 4'd6, 4'd7: return "R4";
         4'd8, 4'd9:  return "R5";
         4'd10:       return (!f[2] && f[0]) ? "R7" : "R6";
         4'd11, 4'd12, 4'd13: return "R8";
         4'd14:       return "R9";
         default:     return "R10";
      endcase
   endfunction

   task automatic model();
      int a, b, c, r, s, adj;
      bit z, n, h, cy;
      a = acc_in; b = opnd_in; c = flags_in[0];
      z = flags_in[3]; n = flags_in[2]; h = flags_in[1]; cy = flags_in[0];
      e_res = acc_in; e_rwe = 0; e_wide = 16'h0; e_wwe = 0; e_we = 4'b0000;
      case (op)
         4'd0, 4'd1: begin
            if (op == 4'd0) c = 0;
            s = a + b + c; r = s % 256;
            z = (r == 0); n = 0; h = ((a % 16) + (b % 16) + c) > 15; cy = s > 255;
            e_res = 8'(r); e_rwe = 1; e_we = 4'b1111;
         end
         4'd2, 4'd3, 4'd4: begin
            if (op != 4'd3) c = 0;
            r = (a - b - c + 512) % 256;
            z = (r == 0); n = 1; h = (a % 16) < ((b % 16) + c); cy = a < (b + c);
            e_res = 8'(r); e_rwe = (op != 4'd4); e_we = 4'b1111;
         end
         4'd5, 4'd6, 4'd7: begin
            r = (op == 4'd5) ? (a & b) : (op == 4'd6) ? (a ^ b) : (a | b);
            z = (r == 0); n = 0; h = (op == 4'd5); cy = 0;
            e_res = 8'(r); e_rwe = 1; e_we = 4'b1111;
         end
         4'd8: begin
            r = (b + 1) % 256; z = (r == 0); n = 0; h = (b % 16) == 15;
            e_res = 8'(r); e_rwe = 1; e_we = 4'b1110;
         end
         4'd9: begin
            r = (b + 255) % 256; z = (r == 0); n = 1; h = (b % 16) == 0;
            e_res = 8'(r); e_rwe = 1; e_we = 4'b1110;
         end
         4'd10: begin
            adj = 0;
            if (h || (!n && (a % 16) > 9)) adj += 6;
            if (cy || (!n && a > 153)) begin adj += 96; cy = 1; end else cy = 0;
            r = n ? ((a - adj + 256) % 256) : ((a + adj) % 256);
            z = (r == 0); h = 0;
            e_res = 8'(r); e_rwe = 1; e_we = 4'b1011;
         end
         4'd11: begin
            e_res = ~acc_in; e_rwe = 1; n = 1; h = 1; e_we = 4'b0110;
         end
         4'd12: begin n = 0; h = 0; cy = 1; e_we = 4'b0111; end
         4'd13: begin n = 0; h = 0; cy = !cy; e_we = 4'b0111; end
         4'd14: begin
            s = int'(hl_in) + int'(rr_in);
            e_wide = 16'(s); e_wwe = 1; n = 0;
            h = (int'(hl_in % 4096) + int'(rr_in % 4096)) > 4095; cy = s > 65535;
            e_we = 4'b0111;
         end
         default: ;
      endcase
      e_fl = {z, n, h, cy};
   endtask

   task automatic compare_now();
      bit bad;
      string t;
      model();
      t = tag_of(op, flags_in);
      bad = (res_we !== e_rwe) || (wide_we !== e_wwe) || (flags_out !== e_fl) ||
            (flag_we !== e_we) || (e_rwe && result !== e_res) ||
            (e_wwe && wide_result !== e_wide);
      n_checks++;
      if (bad) begin
         n_fail++;
         $display("FAIL %s op=%0d a=%h b=%h f=%b: got res=%h/%b wide=%h/%b fl=%b we=%b exp res=%h/%b wide=%h/%b fl=%b we=%b",
                  t, op, acc_in, opnd_in, flags_in, result, res_we, wide_result, wide_we,
                  flags_out, flag_we, e_res, e_rwe, e_wide, e_wwe, e_fl, e_we);
      end
   endtask

   task automatic apply(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                        input logic [15:0] p, input logic [15:0] q, input logic [3:0] f);
      @(posedge clk);
      #1;
      op = o; acc_in = a; opnd_in = b; hl_in = p; rr_in = q; flags_in = f;
      @(negedge clk);
      compare_now();
   endtask

   initial begin
      op = 4'd15; acc_in = 8'h00; opnd_in = 8'h00; hl_in = 16'h0; rr_in = 16'h0; flags_in = 4'b0000;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare_now();                                  // R10 idle state, no writes
      apply(4'd0,  8'h0F, 8'h01, 0, 0, 4'b0000);      // R1 nibble carry
      apply(4'd0,  8'hFF, 8'h01, 0, 0, 4'b0000);      // R1 zero with carry
      apply(4'd1,  8'h0E, 8'h01, 0, 0, 4'b0001);      // R1 carry in feeds H
      apply(4'd2,  8'h10, 8'h01, 0, 0, 4'b0000);      // R2 nibble borrow
      apply(4'd3,  8'h00, 8'h00, 0, 0, 4'b0001);      // R2 borrow in
      apply(4'd4,  8'h42, 8'h42, 0, 0, 4'b0000);      // R3 equal compare
      apply(4'd5,  8'hF0, 8'h0F, 0, 0, 4'b0001);      // R4 AND zero
      apply(4'd6,  8'hAA, 8'hAA, 0, 0, 4'b1111);      // R4 XOR
      apply(4'd7,  8'h00, 8'h80, 0, 0, 4'b1111);      // R4 OR
      apply(4'd8,  8'h00, 8'hFF, 0, 0, 4'b0001);      // R5 wrap keeps C=1
      apply(4'd9,  8'h00, 8'h10, 0, 0, 4'b0000);      // R5 nibble borrow, C=0 kept
      apply(4'd10, 8'h0A, 8'h00, 0, 0, 4'b0000);      // R6 low digit fix
      apply(4'd10, 8'h9A, 8'h00, 0, 0, 4'b0000);      // R6 both fixes to zero
      apply(4'd10, 8'h0F, 8'h00, 0, 0, 4'b0110);      // R6 subtract path
      apply(4'd10, 8'h05, 8'h00, 0, 0, 4'b0001);      // R7 sticky carry
      apply(4'd11, 8'h5A, 8'h00, 0, 0, 4'b1001);      // R8 complement
      apply(4'd12, 8'h00, 8'h00, 0, 0, 4'b0110);      // R8 set carry
      apply(4'd13, 8'h00, 8'h00, 0, 0, 4'b1001);      // R8 complement carry
      apply(4'd14, 8'h00, 8'h00, 16'h0FFF, 16'h0001, 4'b1000); // R9 bit-11 carry
      apply(4'd14, 8'h00, 8'h00, 16'hFFFF, 16'h0001, 4'b0100); // R9 full carry
      apply(4'd15, 8'h12, 8'h34, 0, 0, 4'b1010);      // R10 no-op passes flags
      for (int i = 0; i < 3000; i++) begin
         apply(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom),
               16'($urandom), 16'($urandom), 4'($urandom));
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule